// File: doc/BRIEF.md
# Block Cipher Chaining Mode Controller

This block sits between a data stream and an external block-cipher core, and applies one of two chaining modes to each block: cipher block chaining (CBC) or counter mode. The core is not part of this block. The two sides meet at a one-cycle start pulse, a direction bit, an input word, and a one-cycle done pulse that carries the core's result. The block width is set by a single parameter, so the same controller can drive a 64-bit or a 128-bit cipher. A core that makes several passes per block, such as a triple-pass cipher, only lengthens the gap between start and done. The controller needs no changes for it.

One register holds the chaining state. In CBC it is the last ciphertext, and it starts as the initialisation value. In counter mode it is the running counter. Software-side logic loads that register through an initialisation-value port. Data blocks arrive on a valid/ready handshake. Each result leaves with a single-cycle valid strobe. The block takes one data block at a time, so the input is held off while the core is working.

Top module: `blkmode_ctrl`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, core_start is 0, and the chaining register is all zeros, so the first counter-mode block encrypts the value 0.
- R2: In CBC with dir_dec = 0, the core receives in_data XOR chain with core_dec = 0. out_data equals the core result, and that result becomes the new chain value.
- R3: In CBC with dir_dec = 1, the core receives in_data unchanged with core_dec = 1. out_data equals core result XOR chain, and the incoming ciphertext becomes the new chain value.
- R4: In counter mode (mode_ctr = 1), the core receives the counter with core_dec = 0 whatever dir_dec is. out_data equals in_data XOR core result. The counter then advances by one modulo 2^BLK_W, so all ones wraps to zero.
- R5: An iv_load while no block is in progress writes iv_value into the chaining register for the next block. in_ready is 0 in any cycle in which iv_load is 1.
- R6: An iv_load while a block is in progress does not affect that block. The loaded value replaces the chain update when the block completes. The chaining register never changes while a block is in progress.
- R7: A block is accepted on a clock edge with in_valid and in_ready both high. core_start is high for exactly the following cycle. in_ready stays low from acceptance until the cycle after core_done.
- R8: out_valid is high for exactly one cycle per block, in the cycle after core_done, and out_data holds the result in that cycle.
- R9: mode_ctr and dir_dec are captured when a block is accepted. Changes to them while the block is in progress do not affect that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ctr | input | 1 | 0 = CBC, 1 = counter mode |
| dir_dec | input | 1 | 0 = encrypt, 1 = decrypt (ignored in counter mode) |
| iv_load | input | 1 | Load the chaining/counter register |
| iv_value | input | BLK_W | Value to load |
| in_valid | input | 1 | Input block valid |
| in_data | input | BLK_W | Input block (plaintext or ciphertext) |
| in_ready | output | 1 | Controller can accept a block |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | BLK_W | Result block |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_din | output | BLK_W | Cipher core input word |
| core_dec | output | 1 | Cipher core direction (1 = inverse) |
| core_done | input | 1 | Cipher core completion pulse |
| core_dout | input | BLK_W | Cipher core result, valid with core_done |

## Verification
On every cycle, the assertions check the handshake timing:
- the start pulse follows acceptance;
- ready stays low while busy;
- the single-cycle result strobe appears after done.

They also check how the chaining register moves. It is frozen mid-block, it steps by one in counter mode, it takes the ciphertext after CBC encryption, and it takes a loaded value when idle. The bench scenarios show what no single-cycle property can:
- that long CBC chains decrypt back to the original plaintext;
- that the counter wraps correctly;
- that a value loaded mid-block lands on the following block and not the current one;
- that mode changes during a block are ignored.

// File: rtl/blkmode_pkg.sv
package blkmode_pkg;
  typedef enum logic { CHAIN_CBC = 1'b0, CHAIN_CTR = 1'b1 } chain_mode_e;
  typedef enum logic { SEQ_IDLE = 1'b0, SEQ_BUSY = 1'b1 } seq_state_e;
endpackage

// File: rtl/blkmode_feed.sv
// Builds the word handed to the cipher core and its direction bit.
module blkmode_feed
  import blkmode_pkg::*;
#(
  parameter int BLK_W = 64
) (
  input  chain_mode_e      mode,
  input  logic             dec,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] chain,
  output logic [BLK_W-1:0] core_word,
  output logic             core_inv
);
  function automatic logic [BLK_W-1:0] pick_word(chain_mode_e m, logic d,
                                                  logic [BLK_W-1:0] x,
                                                  logic [BLK_W-1:0] c);
    if (m == CHAIN_CTR) return c;       // keystream from counter
    else if (d)         return x;       // CBC decrypt: raw ciphertext
    else                return x ^ c;   // CBC encrypt: whitened plaintext
  endfunction

  always_comb begin
    core_word = pick_word(mode, dec, data, chain);
    core_inv  = (mode == CHAIN_CBC) && dec;
  end
endmodule

// File: rtl/blkmode_merge.sv
// Combines the core result with the held block and computes the next chain value.
module blkmode_merge
  import blkmode_pkg::*;
#(
  parameter int BLK_W = 64
) (
  input  chain_mode_e      mode,
  input  logic             dec,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] chain,
  input  logic [BLK_W-1:0] core_res,
  output logic [BLK_W-1:0] result,
  output logic [BLK_W-1:0] chain_next
);
  function automatic logic [BLK_W-1:0] form_result(chain_mode_e m, logic d,
                                                    logic [BLK_W-1:0] x,
                                                    logic [BLK_W-1:0] c,
                                                    logic [BLK_W-1:0] r);
    if (m == CHAIN_CTR) return x ^ r;
    else if (d)         return r ^ c;
    else                return r;
  endfunction

  function automatic logic [BLK_W-1:0] form_next(chain_mode_e m, logic d,
                                                  logic [BLK_W-1:0] x,
                                                  logic [BLK_W-1:0] c,
                                                  logic [BLK_W-1:0] r);
    if (m == CHAIN_CTR) return c + {{(BLK_W-1){1'b0}}, 1'b1};
    else if (d)         return x;
    else                return r;
  endfunction

  always_comb begin
    result     = form_result(mode, dec, data, chain, core_res);
    chain_next = form_next(mode, dec, data, chain, core_res);
  end
endmodule

// File: rtl/blkmode_seq.sv
// Two-state sequencer: one block in flight at a time.
module blkmode_seq
  import blkmode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic iv_load,
  input  logic core_done,
  output logic in_ready,
  output logic accept,
  output logic busy,
  output logic blk_done
);
  seq_state_e state_q;

  always_comb begin
    busy     = (state_q == SEQ_BUSY);
    in_ready = !busy && !iv_load;
    accept   = in_valid && in_ready;
    blk_done = busy && core_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= SEQ_IDLE;
    else if (accept)   state_q <= SEQ_BUSY;
    else if (blk_done) state_q <= SEQ_IDLE;
  end
endmodule

// File: rtl/blkmode_ctrl.sv
module blkmode_ctrl
  import blkmode_pkg::*;
#(
  parameter int BLK_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ctr,
  input  logic             dir_dec,
  input  logic             iv_load,
  input  logic [BLK_W-1:0] iv_value,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_data,
  output logic             core_start,
  output logic [BLK_W-1:0] core_din,
  output logic             core_dec,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_dout
);
  // Named internal events (also observed by the bound checker)
  logic             accept_w;
  logic             busy_w;
  logic             blk_done_w;
  logic             mode_is_ctr_w;

  // Captured block context
  chain_mode_e      mode_q;
  logic             dec_q;
  logic [BLK_W-1:0] data_q;
  logic [BLK_W-1:0] chain_q;
  logic             pend_q;
  logic [BLK_W-1:0] pend_val_q;

  // Datapath results
  chain_mode_e      mode_live;
  logic [BLK_W-1:0] feed_word;
  logic             feed_inv;
  logic [BLK_W-1:0] merge_res;
  logic [BLK_W-1:0] merge_next;

  assign mode_live     = mode_ctr ? CHAIN_CTR : CHAIN_CBC;
  assign mode_is_ctr_w = (mode_q == CHAIN_CTR);

  blkmode_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .iv_load  (iv_load),
    .core_done(core_done),
    .in_ready (in_ready),
    .accept   (accept_w),
    .busy     (busy_w),
    .blk_done (blk_done_w)
  );

  blkmode_feed #(.BLK_W(BLK_W)) u_feed (
    .mode     (mode_live),
    .dec      (dir_dec),
    .data     (in_data),
    .chain    (chain_q),
    .core_word(feed_word),
    .core_inv (feed_inv)
  );

  blkmode_merge #(.BLK_W(BLK_W)) u_merge (
    .mode      (mode_q),
    .dec       (dec_q),
    .data      (data_q),
    .chain     (chain_q),
    .core_res  (core_dout),
    .result    (merge_res),
    .chain_next(merge_next)
  );

  // Capture of block context and core request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= CHAIN_CBC;
      dec_q      <= 1'b0;
      data_q     <= '0;
      core_din   <= '0;
      core_dec   <= 1'b0;
      core_start <= 1'b0;
    end else begin
      core_start <= accept_w;
      if (accept_w) begin
        mode_q   <= mode_live;
        dec_q    <= dir_dec;
        data_q   <= in_data;
        core_din <= feed_word;
        core_dec <= feed_inv;
      end
    end
  end

  // Chaining register with deferred load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q    <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else begin
      if (!busy_w && iv_load) begin
        chain_q <= iv_value;
      end else if (blk_done_w) begin
        if (iv_load)     chain_q <= iv_value;
        else if (pend_q) chain_q <= pend_val_q;
        else             chain_q <= merge_next;
      end
      if (blk_done_w) begin
        pend_q <= 1'b0;
      end else if (busy_w && iv_load) begin
        pend_q     <= 1'b1;
        pend_val_q <= iv_value;
      end
    end
  end

  // Result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= blk_done_w;
      if (blk_done_w) out_data <= merge_res;
    end
  end
endmodule

// File: rtl/blkmode_ctrl_chk.sv
module blkmode_ctrl_chk #(
  parameter int BLK_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             iv_load,
  input logic [BLK_W-1:0] iv_value,
  input logic             out_valid,
  input logic [BLK_W-1:0] out_data,
  input logic             core_start,
  input logic             core_dec,
  input logic             busy,
  input logic             blk_done,
  input logic             mode_is_ctr,
  input logic             dec_q,
  input logic             pend_q,
  input logic [BLK_W-1:0] chain_q
);
  AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> core_start); // R7
  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R7
  AST_READY_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    iv_load |-> !in_ready); // R5
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> out_valid); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8
  AST_CTR_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    core_start && mode_is_ctr |-> !core_dec); // R4
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && mode_is_ctr && !pend_q && !iv_load |=>
      chain_q == BLK_W'($past(chain_q) + 1'b1)); // R4
  AST_CBC_ENC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && !mode_is_ctr && !dec_q && !pend_q && !iv_load |=>
      chain_q == out_data); // R2
  AST_CHAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !blk_done |=> $stable(chain_q)); // R6
  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && iv_load |=> chain_q == $past(iv_value)); // R5
endmodule

bind blkmode_ctrl blkmode_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .iv_load    (iv_load),
  .iv_value   (iv_value),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .core_start (core_start),
  .core_dec   (core_dec),
  .busy       (busy_w),
  .blk_done   (blk_done_w),
  .mode_is_ctr(mode_is_ctr_w),
  .dec_q      (dec_q),
  .pend_q     (pend_q),
  .chain_q    (chain_q)
);

// File: tb/blkmode_ctrl_test.sv
module blkmode_ctrl_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ctr = 1'b0, dir_dec = 1'b0, iv_load = 1'b0, in_valid = 1'b0;
  logic [W-1:0] iv_value = '0, in_data = '0;
  logic in_ready, out_valid, core_start, core_dec, core_done;
  logic [W-1:0] out_data, core_din, core_dout;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int starts = 0;
  logic [W-1:0] rc;              // bench's own chain model
  logic [W-1:0] cts [0:599];

  always #4 clk = ~clk;          // 125 MHz

  blkmode_ctrl #(.BLK_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_ctr(mode_ctr), .dir_dec(dir_dec),
    .iv_load(iv_load), .iv_value(iv_value), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .core_start(core_start), .core_din(core_din),
    .core_dec(core_dec), .core_done(core_done), .core_dout(core_dout)
  );

  // Stand-in invertible permutation
  function automatic logic [W-1:0] perm(logic [W-1:0] x);
    logic [W-1:0] t = x ^ 16'hA5C3;
    return {t[W-6:0], t[W-1:W-5]} + 16'h3B19;
  endfunction
  function automatic logic [W-1:0] perm_inv(logic [W-1:0] y);
    logic [W-1:0] t = y - 16'h3B19;
    return {t[4:0], t[W-1:5]} ^ 16'hA5C3;
  endfunction

  // Stand-in core with variable latency
  logic [W-1:0] cq;
  logic cinv;
  int cnt = 0;
  always @(posedge clk) begin
    core_done <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        core_done <= 1'b1;
        core_dout <= cinv ? perm_inv(cq) : perm(cq);
      end
    end else if (core_start) begin
      cq    <= core_din;
      cinv  <= core_dec;
      cnt   <= lat;
      starts <= starts + 1;
    end
  end
  initial begin core_done = 1'b0; core_dout = '0; end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Send one block; optional mid-block load and mode flip.
  task automatic send(input logic [W-1:0] d, input logic [W-1:0] exp,
                      input string req, input bit midload = 0,
                      input logic [W-1:0] mid_iv = '0);
    logic m0, d0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(core_start == 1'b1, "R7 start after accept", W'(core_start), W'(1));
    chk(in_ready == 1'b0, "R7 ready low busy", W'(in_ready), W'(0));
    m0 = mode_ctr; d0 = dir_dec;
    if (midload) begin
      iv_load = 1'b1; iv_value = mid_iv;
      mode_ctr = ~mode_ctr; dir_dec = ~dir_dec;   // R9 stimulus
      @(negedge clk);
      iv_load = 1'b0;
      chk(core_start == 1'b0, "R7 start single", W'(core_start), W'(0));
    end
    while (!out_valid) begin
      chk(in_ready == 1'b0, "R7 ready low busy", W'(in_ready), W'(0));
      @(negedge clk);
    end
    chk(out_data == exp, req, out_data, exp);
    mode_ctr = m0; dir_dec = d0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid pulse", W'(out_valid), W'(0));
    chk(in_ready == 1'b1, "R7 ready after done", W'(in_ready), W'(1));
  endtask

  task automatic load_iv(input logic [W-1:0] v);
    @(negedge clk);
    iv_load = 1'b1; iv_value = v; in_valid = 1'b1; in_data = 16'h1234;
    #1;
    chk(in_ready == 1'b0, "R5 ready low on load", W'(in_ready), W'(0));
    @(negedge clk);
    iv_load = 1'b0; in_valid = 1'b0;
    rc = v;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pt, ct, d;
    int s0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", W'(in_ready), W'(1));
    chk(out_valid == 1'b0, "R1 reset valid", W'(out_valid), W'(0));
    chk(core_start == 1'b0, "R1 reset start", W'(core_start), W'(0));
    rst_n = 1'b1;
    rc = '0;

    // R1/R4: counter from reset value 0
    mode_ctr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      d = W'(i * 16'h1111);
      send(d, d ^ perm(rc), "R1 R4 ctr from reset");
      rc = rc + 1'b1;
    end

    // R2: long CBC encrypt chain, varying core latency
    mode_ctr = 1'b0; dir_dec = 1'b0;
    load_iv(16'h5A5A);
    s0 = starts;
    for (int i = 0; i < 600; i++) begin
      lat = (i % 3) + 1;
      pt = W'(i * 16'h9E37);
      ct = perm(pt ^ rc);
      send(pt, ct, "R2 cbc encrypt");
      cts[i] = ct; rc = ct;
    end
    chk(starts - s0 == 600, "R7 one start per block", W'(starts - s0), W'(600));

    // R3: decrypt back to plaintext
    dir_dec = 1'b1;
    load_iv(16'h5A5A);
    for (int i = 0; i < 600; i++) begin
      lat = 3 - (i % 3);
      send(cts[i], W'(i * 16'h9E37), "R3 cbc decrypt");
      rc = cts[i];
    end

    // R4: counter sweep across wrap, both dir settings
    mode_ctr = 1'b1; lat = 1;
    load_iv(16'hF800);
    for (int i = 0; i < 4096; i++) begin
      dir_dec = i[0];
      d = W'(i * 16'h0F0F + 3);
      send(d, d ^ perm(rc), "R4 ctr sweep wrap");
      rc = rc + 1'b1;
    end
    chk(rc == 16'h0800, "R4 wrap model", rc, 16'h0800);

    // R6/R9: mid-block load and mode flip, CBC encrypt
    mode_ctr = 1'b0; dir_dec = 1'b0; lat = 3;
    load_iv(16'h0101);
    pt = 16'hBEEF;
    ct = perm(pt ^ rc);
    send(pt, ct, "R6 R9 midblock load and flip", 1'b1, 16'hC3C3);
    rc = 16'hC3C3;
    pt = 16'h0F0F;
    send(pt, perm(pt ^ rc), "R6 load applied next block");
    rc = perm(pt ^ rc);

    // R9: counter block with flip to CBC decrypt mid-block
    mode_ctr = 1'b1; dir_dec = 1'b0;
    load_iv(16'h7777);
    d = 16'h2468;
    send(d, d ^ perm(rc), "R9 ctr held during flip", 1'b1, 16'h9999);
    rc = 16'h9999;
    send(d, d ^ perm(rc), "R6 R4 ctr after deferred load");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule